// File: doc/BRIEF.md
# Packed Saturating Vector Add/Subtract Unit

This block takes one 32-bit instruction word from the unpredicated integer add/subtract group and applies the chosen operation to every lane of two packed vector operands. The lane size comes from the instruction, so one datapath serves 8-, 16-, 32- and 64-bit lanes. The available operations are wrapping add and subtract, plus add and subtract that saturate as signed or as unsigned values.

A front end presents the word with a valid strobe and the two source vectors, which were read out of the register file using the indices the block decodes. One clock later the unit returns the result vector, the destination index and a result-valid strobe. It raises an illegal flag instead when the word is not a member of the group. Predication, other instruction groups and hazard handling belong to the surrounding pipeline.

Top module: `sat_vec_alu`

## Requirements
- R1: A word belongs to the group only when bits [31:24] are 8'b00000100, bit 21 is 1 and bits [15:13] are 3'b000. Any other word accepted with `inValid` gives `illegal`=1 and `outValid`=0 one cycle later.
- R2: Bits [12:10] pick the operation: 000 is wrapping add, 001 is wrapping subtract, 100 is signed saturating add, 101 is unsigned saturating add, 110 is signed saturating subtract and 111 is unsigned saturating subtract.
- R3: Bits [23:22] choose the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. `VEC_W` must be a multiple of 64.
- R4: The destination index comes from bits [4:0], the first source from bits [9:5] and the second source from bits [20:16]. Each appears on its own output together with the result.
- R5: Wrapping forms return each lane modulo 2^n. No carry or borrow crosses a lane boundary.
- R6: Signed saturating forms clamp each lane to the range -2^(n-1) to 2^(n-1)-1.
- R7: The unsigned saturating add clamps at 2^n-1, and the unsigned saturating subtract clamps at 0.
- R8: Operation codes 010 and 011 are illegal. When the word is illegal, the result and the index outputs keep their previous values.
- R9: A legal word with `inValid` gives `outValid`=1 on the following cycle only. With no `inValid`, both `outValid` and `illegal` are 0 on the next cycle.
- R10: A synchronous reset clears `outValid`, `illegal` and `result`.
- R11: The operation is unpredicated: every lane across the full vector width is computed and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Instruction word |
| opA | input | VEC_W | First source vector |
| opB | input | VEC_W | Second source vector |
| result | output | VEC_W | Lane-wise result |
| dstIdx | output | 5 | Destination register index |
| srcAIdx | output | 5 | First source register index |
| srcBIdx | output | 5 | Second source register index |
| outValid | output | 1 | Result is valid (one cycle) |
| illegal | output | 1 | Word was not a legal member of the group |

## Verification
Every output is registered exactly once. The result, the three indices, `outValid` and `illegal` for a word are therefore due one clock after the edge that samples its `inValid`, and they stay there until the next accepted word. The bench drives each word on a falling edge and holds it for one full cycle. It reads the outputs on the next falling edge, so the sample always falls after the single capturing edge. A second read one cycle later confirms that `outValid` has dropped while the result is held.

// File: rtl/sat_vec_alu_pkg.sv
package sat_vec_alu_pkg;

  // strobes from decode to the lane datapath
  typedef struct packed {
    logic       load;    // capture a new result
    logic       doSub;   // subtract instead of add
    logic       sat;     // saturate instead of wrap
    logic       uns;     // unsigned saturation bounds
    logic [1:0] size;    // lane width selector: 8 << size bits
  } dpCtrl_t;

  localparam logic [7:0] GROUP_TOP = 8'b0000_0100;

endpackage

// File: rtl/sat_vec_lane.sv
module sat_vec_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         doSub,
  input  logic         sat,
  input  logic         uns,
  output logic [W-1:0] y
);

  logic [W:0]   ext;
  logic [W-1:0] raw;
  logic         carry;
  logic         sOvf;
  logic [W-1:0] sLim;
  logic [W-1:0] uLim;

  always_comb begin
    ext   = doSub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    raw   = ext[W-1:0];
    carry = ext[W];
    if (doSub) sOvf = (a[W-1] != b[W-1]) && (raw[W-1] != a[W-1]);
    else       sOvf = (a[W-1] == b[W-1]) && (raw[W-1] != a[W-1]);
    sLim  = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    uLim  = doSub ? {W{1'b0}} : {W{1'b1}};
    if (!sat)     y = raw;
    else if (uns) y = carry ? uLim : raw;
    else          y = sOvf ? sLim : raw;
  end

endmodule

// File: rtl/sat_vec_ctrl.sv
module sat_vec_ctrl
  import sat_vec_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] instr,
  output dpCtrl_t     dpCtl,
  output logic [4:0]  dstIdx,
  output logic [4:0]  srcAIdx,
  output logic [4:0]  srcBIdx,
  output logic        outValid,
  output logic        illegal
);

  logic       groupHit;
  logic [2:0] opc;
  logic       opcOk;
  logic       legal;

  always_comb begin
    groupHit    = (instr[31:24] == GROUP_TOP) && instr[21] && (instr[15:13] == 3'b000);
    opc         = instr[12:10];
    opcOk       = (opc != 3'b010) && (opc != 3'b011);
    legal       = groupHit && opcOk;
    dpCtl.load  = inValid && legal;
    dpCtl.sat   = opc[2];
    dpCtl.doSub = opc[2] ? opc[1] : opc[0];
    dpCtl.uns   = opc[0];
    dpCtl.size  = instr[23:22];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
      dstIdx   <= '0;
      srcAIdx  <= '0;
      srcBIdx  <= '0;
    end else begin
      outValid <= inValid && legal;
      illegal  <= inValid && !legal;
      if (inValid && legal) begin
        dstIdx  <= instr[4:0];
        srcAIdx <= instr[9:5];
        srcBIdx <= instr[20:16];
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !illegal));

  // R1
  valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (outValid != illegal));

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(dstIdx) && $stable(srcAIdx) && $stable(srcBIdx)));

endmodule

// File: rtl/sat_vec_datapath.sv
module sat_vec_datapath
  import sat_vec_alu_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCtrl_t          dpCtl,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] result
);

  localparam int NUM_SIZES = 4;

  logic [VEC_W-1:0] sizeRes [NUM_SIZES];
  logic [VEC_W-1:0] nextRes;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      sat_vec_lane #(.W(LW)) i_lane (
        .a     (opA[l*LW +: LW]),
        .b     (opB[l*LW +: LW]),
        .doSub (dpCtl.doSub),
        .sat   (dpCtl.sat),
        .uns   (dpCtl.uns),
        .y     (sizeRes[s][l*LW +: LW])
      );
    end
  end

  always_comb nextRes = sizeRes[dpCtl.size];

  always_ff @(posedge clk) begin
    if (rst)             result <= '0;
    else if (dpCtl.load) result <= nextRes;
  end

  // R7
  uns_add_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (dpCtl.load && dpCtl.sat && dpCtl.uns && !dpCtl.doSub && dpCtl.size == 2'd0)
      |=> (result[7:0] >= $past(opA[7:0])));

  // R7
  uns_sub_ceil_chk: assert property (@(posedge clk) disable iff (rst)
    (dpCtl.load && dpCtl.sat && dpCtl.uns && dpCtl.doSub && dpCtl.size == 2'd0)
      |=> (result[7:0] <= $past(opA[7:0])));

endmodule

// File: rtl/sat_vec_alu.sv
module sat_vec_alu
  import sat_vec_alu_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [31:0]      instr,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] result,
  output logic [4:0]       dstIdx,
  output logic [4:0]       srcAIdx,
  output logic [4:0]       srcBIdx,
  output logic             outValid,
  output logic             illegal
);

  dpCtrl_t dpCtl;

  sat_vec_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .instr    (instr),
    .dpCtl    (dpCtl),
    .dstIdx   (dstIdx),
    .srcAIdx  (srcAIdx),
    .srcBIdx  (srcBIdx),
    .outValid (outValid),
    .illegal  (illegal)
  );

  sat_vec_datapath #(.VEC_W(VEC_W)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .dpCtl  (dpCtl),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(result));

endmodule

// File: tb/test_sat_vec_alu.sv
module test_sat_vec_alu;

  localparam int VW = 128;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VW-1:0] opA = '0;
  logic [VW-1:0] opB = '0;
  logic [VW-1:0] result;
  logic [4:0]    dstIdx, srcAIdx, srcBIdx;
  logic          outValid, illegal;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sat_vec_alu #(.VEC_W(VW)) i_sat_vec_alu (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .opA(opA), .opB(opB), .result(result), .dstIdx(dstIdx),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .outValid(outValid), .illegal(illegal)
  );

  // stimulus table: operation, size, operands
  localparam logic [2:0] T_OP [NV] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111,
                                       3'b000, 3'b100, 3'b111, 3'b110, 3'b101, 3'b001};
  localparam logic [1:0] T_SZ [NV] = '{2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd3,
                                       2'd3, 2'd2, 2'd0, 2'd1, 2'd3, 2'd2};
  localparam logic [VW-1:0] T_A [NV] = '{
    128'h7F80_FF01_0000_FFFF_8000_7FFF_1234_5678,
    128'h0000_8000_7FFF_FFFF_0001_1234_ABCD_0000,
    128'h7F7F_8080_0102_F0F0_7F01_80FF_4040_C0C0,
    128'hFFFF_0001_8000_7FFF_FFF0_0000_1234_FFFE,
    128'h7FFF_FFFF_8000_0000_0000_0001_FFFF_FFFF,
    128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF,
    128'hFFFF_FFFF_FFFF_FFFF_7FFF_FFFF_FFFF_FFFF,
    128'h7FFF_FFFF_8000_0000_1234_5678_FFFF_FFFE,
    128'h0001_0203_FF00_8081_1020_3040_FFFF_0000,
    128'h8000_7FFF_0000_FFFF_1234_8001_7FFE_0005,
    128'hFFFF_FFFF_FFFF_FFF0_0123_4567_89AB_CDEF,
    128'h0000_0000_8000_0000_FFFF_FFFF_0000_0001};
  localparam logic [VW-1:0] T_B [NV] = '{
    128'h0101_0101_0001_0001_8000_0001_1111_1111,
    128'h0001_0001_8000_FFFF_0002_4321_0001_0001,
    128'h0180_FF80_7F7F_1010_017F_FF80_4040_C0C0,
    128'h0001_FFFF_8000_8001_0020_0000_FFFF_0001,
    128'hFFFF_FFFF_0000_0001_8000_0000_7FFF_FFFF,
    128'h0000_0000_0000_0002_0000_0000_0000_0001,
    128'h0000_0000_0000_0001_8000_0000_0000_0001,
    128'h0000_0001_FFFF_FFFF_1234_5678_0000_0003,
    128'h0102_0102_0100_8180_0F21_3041_0000_0001,
    128'h0001_FFFF_8000_7FFF_1234_0002_FFFF_8000,
    128'h0000_0000_0000_0020_FEDC_BA98_7654_3210,
    128'h0000_0001_0000_0001_0000_0001_0000_0002};

  function automatic logic [31:0] mkInstr(logic [2:0] op, logic [1:0] sz,
                                          logic [4:0] rd, logic [4:0] rn, logic [4:0] rm);
    return {8'b0000_0100, sz, 1'b1, rm, 3'b000, op, rn, rd};
  endfunction

  // independent lane-by-lane reference, widened so that no bound is lost
  function automatic logic [VW-1:0] refOp(logic [2:0] op, logic [1:0] sz,
                                          logic [VW-1:0] a, logic [VW-1:0] b);
    logic [VW-1:0] res = '0;
    int w = 8 << sz;
    logic [VW-1:0] mask = (w == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << w) - 128'd1);
    for (int i = 0; i < VW / w; i++) begin
      logic [63:0] ua = 64'((a >> (i * w)) & mask);
      logic [63:0] ub = 64'((b >> (i * w)) & mask);
      logic signed [67:0] sa = $signed({4'd0, ua});
      logic signed [67:0] sb = $signed({4'd0, ub});
      logic signed [67:0] r;
      logic signed [67:0] smax = (68'sd1 <<< (w - 1)) - 68'sd1;
      logic signed [67:0] smin = -(68'sd1 <<< (w - 1));
      logic signed [67:0] umax = (68'sd1 <<< w) - 68'sd1;
      if (op == 3'b100 || op == 3'b110) begin
        if (ua[w-1]) sa = sa - (68'sd1 <<< w);
        if (ub[w-1]) sb = sb - (68'sd1 <<< w);
      end
      r = (op == 3'b001 || op == 3'b110 || op == 3'b111) ? sa - sb : sa + sb;
      if (op == 3'b100 || op == 3'b110) begin
        if (r > smax) r = smax;
        if (r < smin) r = smin;
      end else if (op == 3'b101 || op == 3'b111) begin
        if (r > umax) r = umax;
        if (r < 0)    r = 0;
      end
      res = res | ((128'(r) & mask) << (i * w));
    end
    return res;
  endfunction

  task automatic chkVec(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one word for one cycle; returns at the falling edge after capture
  task automatic issue(logic [31:0] w, logic [VW-1:0] a, logic [VW-1:0] b);
    @(negedge clk);
    instr = w; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    chkBit("R10 outValid", {7'd0, outValid}, 8'd0);
    chkBit("R10 illegal", {7'd0, illegal}, 8'd0);
    chkVec("R10 result", result, '0);
    rst = 1'b0;

    // table walk: R2 R3 R5 R6 R7 R11 against the reference
    for (int t = 0; t < NV; t++) begin
      logic [4:0] rd = 5'(t + 1), rn = 5'(t + 9), rm = 5'(31 - t);
      issue(mkInstr(T_OP[t], T_SZ[t], rd, rn, rm), T_A[t], T_B[t]);
      chkVec($sformatf("R2/R3/R5/R6/R7/R11 row %0d", t), result,
             refOp(T_OP[t], T_SZ[t], T_A[t], T_B[t]));
      chkBit("R9 outValid", {7'd0, outValid}, 8'd1);
      chkBit("R4 dstIdx", {3'd0, dstIdx}, {3'd0, rd});
      chkBit("R4 srcAIdx", {3'd0, srcAIdx}, {3'd0, rn});
      chkBit("R4 srcBIdx", {3'd0, srcBIdx}, {3'd0, rm});
    end

    // R6: signed 8-bit clamp, literal expectations
    issue(mkInstr(3'b100, 2'd0, 5'd1, 5'd2, 5'd3), {16{8'h7F}}, {16{8'h01}});
    chkVec("R6 sqadd max", result, {16{8'h7F}});
    issue(mkInstr(3'b110, 2'd0, 5'd1, 5'd2, 5'd3), {16{8'h80}}, {16{8'h01}});
    chkVec("R6 sqsub min", result, {16{8'h80}});
    // R7: unsigned clamps
    issue(mkInstr(3'b101, 2'd0, 5'd1, 5'd2, 5'd3), {16{8'hFF}}, {16{8'h01}});
    chkVec("R7 uqadd top", result, {16{8'hFF}});
    issue(mkInstr(3'b111, 2'd0, 5'd1, 5'd2, 5'd3), {16{8'h00}}, {16{8'h01}});
    chkVec("R7 uqsub zero", result, '0);
    // R5/R3: no carry across lanes, lane width matters
    issue(mkInstr(3'b000, 2'd0, 5'd1, 5'd2, 5'd3), {8{16'h00FF}}, {8{16'h0001}});
    chkVec("R5 8-bit wrap", result, '0);
    issue(mkInstr(3'b000, 2'd1, 5'd1, 5'd2, 5'd3), {8{16'h00FF}}, {8{16'h0001}});
    chkVec("R3 16-bit carry", result, {8{16'h0100}});
    issue(mkInstr(3'b000, 2'd3, 5'd1, 5'd2, 5'd3), {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'd1}});
    chkVec("R5 64-bit wrap", result, '0);
    // R9: single-cycle valid, result held
    held = result;
    @(negedge clk);
    chkBit("R9 valid drops", {7'd0, outValid}, 8'd0);
    chkVec("R9 result held", result, held);

    // R1/R8: illegal words leave result and indices unchanged
    issue(mkInstr(3'b001, 2'd0, 5'd7, 5'd8, 5'd9), {16{8'h10}}, {16{8'h01}});
    held = result;
    issue(mkInstr(3'b010, 2'd0, 5'd20, 5'd21, 5'd22), '1, '1);
    chkBit("R8 opc 010 illegal", {7'd0, illegal}, 8'd1);
    chkBit("R8 opc 010 no valid", {7'd0, outValid}, 8'd0);
    chkVec("R8 result kept", result, held);
    chkBit("R8 dst kept", {3'd0, dstIdx}, 8'd7);
    issue(mkInstr(3'b011, 2'd1, 5'd20, 5'd21, 5'd22), '1, '1);
    chkBit("R8 opc 011 illegal", {7'd0, illegal}, 8'd1);
    issue(mkInstr(3'b000, 2'd0, 5'd20, 5'd21, 5'd22) ^ 32'h0100_0000, '1, '1);
    chkBit("R1 top byte illegal", {7'd0, illegal}, 8'd1);
    issue(mkInstr(3'b000, 2'd0, 5'd20, 5'd21, 5'd22) & ~32'h0020_0000, '1, '1);
    chkBit("R1 bit21 illegal", {7'd0, illegal}, 8'd1);
    issue(mkInstr(3'b000, 2'd0, 5'd20, 5'd21, 5'd22) | 32'h0000_2000, '1, '1);
    chkBit("R1 bits15:13 illegal", {7'd0, illegal}, 8'd1);
    chkVec("R8 result kept after all", result, held);
    chkBit("R8 srcB kept", {3'd0, srcBIdx}, 8'd9);
    @(negedge clk);
    chkBit("R9 illegal drops", {7'd0, illegal}, 8'd0);

    // R10: reset mid-run
    issue(mkInstr(3'b000, 2'd0, 5'd1, 5'd2, 5'd3), {16{8'h11}}, {16{8'h22}});
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chkVec("R10 result cleared", result, '0);
    chkBit("R10 valid cleared", {7'd0, outValid}, 8'd0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule